// File: doc/BRIEF.md
# Frame Pulse Reset Qualifier

This block watches a frame input, sampled on the data clock, and decides which frame pulses may reset the pointers of a downstream FIFO. A pulse qualifies only when it has stayed high for a minimum number of consecutive data-clock cycles. That minimum is one cycle when the interface runs on full words and two cycles when it runs on bytes. The byte-mode minimum is deliberately longer than the width needed only to mark the start of a byte stream. Each qualifying pulse produces at most one single-cycle strike on `strike_o`, and the FIFO pointer logic acts on that strike.

A 2-bit policy field is loaded through a write strobe and decides what happens to qualifying pulses. In the off policy they are dropped. In the repeat policy every one of them strikes. In the single policy only the first one after the field was last written (or after reset) strikes, so a periodic frame cannot keep pushing the FIFO between two states. The single policy is active out of reset. A sticky flag records that a strike has taken place since the last write to the field.

Top module: `frame_reset_qualifier`

## Requirements
- R1: After reset `strike_o` and `done_o` are 0 and the policy is single, armed, so the first qualifying pulse strikes with no write to the field.
- R2: With `byte_mode_i`=0 a pulse high for 1 or more sampled cycles gives one strike, and `strike_o` is high in the cycle after the edge that sampled the first high value.
- R3: With `byte_mode_i`=1 a pulse high for only 1 sampled cycle gives no strike. A pulse high for 2 or more cycles gives one strike, which appears in the cycle after the edge that sampled the second high value.
- R4: A qualifying pulse gives exactly one strike of one cycle however long it stays high, and `strike_o` is never high for two consecutive cycles.
- R5: With policy code 00 (off) no pulse strikes.
- R6: With policy code 01 (repeat) every qualifying pulse strikes.
- R7: With policy code 10 (single) only the first qualifying pulse after the last write strikes. Later pulses are ignored.
- R8: Policy code 11 behaves exactly like code 10.
- R9: Each assertion of `mode_wr_i` loads `mode_i` and re-arms the single policy, even when the same code is written again.
- R10: `done_o` rises in the same cycle as a strike, stays high until the next write to the field, and is cleared by that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Frame input, sampled on the rising edge |
| byte_mode_i | input | 1 | 1 selects byte mode (two-cycle minimum), 0 selects word mode (one-cycle minimum) |
| mode_wr_i | input | 1 | Write strobe for the policy field |
| mode_i | input | 2 | Policy code: 00 off, 01 repeat, 10 single, 11 single |
| strike_o | output | 1 | Single-cycle FIFO pointer reset strike |
| done_o | output | 1 | Sticky flag: a strike has occurred since the last write |

## Verification
The assertions assume that `byte_mode_i` stays constant for the whole of a pulse and that no write to the policy field lands in the same cycle as a qualifying edge. A write that lands there would re-arm the single policy and clear the sticky flag in the cycle they are being judged. The bench changes the interface mode and writes the policy only while the frame input is low and idle, with several idle cycles between pulses. It sweeps every policy code, both interface modes and pulse widths from one to four cycles, and applies two pulses after each write so that both the first and a later pulse are checked.

// File: rtl/frq_pkg.sv
package frq_pkg;
  typedef enum logic [1:0] {
    POL_OFF    = 2'b00,
    POL_REPEAT = 2'b01,
    POL_SINGLE = 2'b10,
    POL_SINGLE_ALT = 2'b11
  } frq_policy_e;

  localparam frq_policy_e POL_RESET = POL_SINGLE;
endpackage

// File: rtl/frq_width_counter.sv
module frq_width_counter #(
  parameter int unsigned WORD_MIN = 1,
  parameter int unsigned BYTE_MIN = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic byte_mode_i,
  output logic hit_o
);
  localparam int unsigned MAX_MIN = (WORD_MIN > BYTE_MIN) ? WORD_MIN : BYTE_MIN;
  localparam int unsigned CNT_W   = $clog2(MAX_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] WORD_TGT = CNT_W'(WORD_MIN - 1);
  localparam logic [CNT_W-1:0] BYTE_TGT = CNT_W'(BYTE_MIN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt;

  assign tgt   = byte_mode_i ? BYTE_TGT : WORD_TGT;
  // qualifies on the single edge where the high run reaches the minimum
  assign hit_o = frame_i && (cnt_q == tgt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!frame_i)       cnt_q <= '0;
    else if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/frq_policy_ctrl.sv
module frq_policy_ctrl
  import frq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_wr_i,
  input  logic [1:0] mode_i,
  input  logic       hit_i,
  output logic       fire_o,
  output logic [1:0] mode_o,
  output logic       armed_o
);
  frq_policy_e pol_q;
  logic        armed_q;
  logic        single;

  assign single = pol_q[1];

  always_comb begin
    unique case (pol_q)
      POL_OFF:    fire_o = 1'b0;
      POL_REPEAT: fire_o = hit_i;
      default:    fire_o = hit_i && armed_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q   <= POL_RESET;
      armed_q <= 1'b1;
    end else if (mode_wr_i) begin
      pol_q   <= frq_policy_e'(mode_i);
      armed_q <= 1'b1;
    end else if (fire_o && single) begin
      armed_q <= 1'b0;
    end
  end

  assign mode_o  = pol_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/frame_reset_qualifier.sv
module frame_reset_qualifier #(
  parameter int unsigned WORD_MIN = 1,
  parameter int unsigned BYTE_MIN = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_i,
  input  logic       byte_mode_i,
  input  logic       mode_wr_i,
  input  logic [1:0] mode_i,
  output logic       strike_o,
  output logic       done_o
);
  logic       hit;
  logic       fire;
  logic [1:0] mode_q;
  logic       armed_q;
  logic       strike_q;
  logic       done_q;

  frq_width_counter #(.WORD_MIN(WORD_MIN), .BYTE_MIN(BYTE_MIN)) u_width (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .byte_mode_i(byte_mode_i),
    .hit_o      (hit)
  );

  frq_policy_ctrl u_policy (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mode_wr_i(mode_wr_i),
    .mode_i   (mode_i),
    .hit_i    (hit),
    .fire_o   (fire),
    .mode_o   (mode_q),
    .armed_o  (armed_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strike_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      strike_q <= fire;
      done_q   <= fire | (done_q & ~mode_wr_i);
    end
  end

  assign strike_o = strike_q;
  assign done_o   = done_q;
endmodule

// File: rtl/frq_checker.sv
module frq_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_i,
  input logic       byte_mode_i,
  input logic       mode_wr_i,
  input logic       strike_o,
  input logic       done_o,
  input logic [1:0] mode_q,
  input logic       armed_q
);
  p_single_cycle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strike_o |=> !strike_o);

  p_off_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 2'b00) |=> !strike_o);

  // R7, R8: a spent single policy stays silent until rewritten
  p_single_spent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q[1] && !armed_q && !mode_wr_i) |=> !strike_o);

  p_byte_width_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strike_o && $past(byte_mode_i)) |-> ($past(frame_i) && $past(frame_i, 2)));

  p_word_width_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strike_o |-> $past(frame_i));

  p_sticky_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !mode_wr_i) |=> done_o);

  p_sticky_rise_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> strike_o);

  p_write_arms_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_wr_i |=> armed_q);
endmodule

bind frame_reset_qualifier frq_checker u_frq_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .byte_mode_i(byte_mode_i),
  .mode_wr_i  (mode_wr_i),
  .strike_o   (strike_o),
  .done_o     (done_o),
  .mode_q     (mode_q),
  .armed_q    (armed_q)
);

// File: tb/frame_reset_qualifier_bench.sv
`timescale 1ns/1ps
module frame_reset_qualifier_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       frame_i = 1'b0;
  logic       byte_mode_i = 1'b0;
  logic       mode_wr_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       strike_o;
  logic       done_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk_i = ~clk_i;

  frame_reset_qualifier u_frame_reset_qualifier (
    .clk_i(clk_i), .rst_ni(rst_ni), .frame_i(frame_i), .byte_mode_i(byte_mode_i),
    .mode_wr_i(mode_wr_i), .mode_i(mode_i), .strike_o(strike_o), .done_o(done_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_mode(input logic [1:0] code);
    @(negedge clk_i);
    mode_i = code; mode_wr_i = 1'b1;
    @(negedge clk_i);
    mode_wr_i = 1'b0;
  endtask

  // drives a pulse of width w; counts strikes and notes the edge index of the first
  task automatic pulse(input int w, output int n, output int first);
    n = 0; first = -1;
    @(negedge clk_i);
    frame_i = 1'b1;
    for (int k = 1; k <= w + 4; k++) begin
      @(posedge clk_i);
      #1;
      if (strike_o) begin
        n++;
        if (first < 0) first = k;
      end
      @(negedge clk_i);
      if (k == w) frame_i = 1'b0;
    end
  endtask

  initial begin
    int n, first, need, valid, exp_n, struck;
    string tag;
    #55;
    check("R1 strike reset", int'(strike_o), 0);
    check("R1 done reset", int'(done_o), 0);
    rst_ni = 1'b1;
    // default single policy, armed without write
    pulse(1, n, first);
    check("R1 default strike", n, 1);
    check("R2 word timing", first, 1);
    check("R10 done after strike", int'(done_o), 1);
    pulse(2, n, first);
    check("R7 default second ignored", n, 0);

    for (int bm = 0; bm < 2; bm++) begin
      for (int code = 0; code < 4; code++) begin
        for (int w = 1; w <= 4; w++) begin
          @(negedge clk_i);
          byte_mode_i = bm[0];
          write_mode(code[1:0]);
          check("R10 cleared by write", int'(done_o), 0);
          need  = bm ? 2 : 1;
          valid = (w >= need) ? 1 : 0;
          tag = (code == 0) ? "R5" : (code == 1) ? "R6" : (code == 2) ? "R7" : "R8";
          struck = 0;
          for (int p = 0; p < 2; p++) begin
            pulse(w, n, first);
            if (code == 0)      exp_n = 0;
            else if (code == 1) exp_n = valid;
            else                exp_n = (valid && struck == 0) ? 1 : 0;
            check($sformatf("%s policy count bm%0d w%0d p%0d (R4)", tag, bm, w, p), n, exp_n);
            if (exp_n == 1)
              check(bm ? "R3 byte timing" : "R2 word timing", first, need);
            struck += exp_n;
            check("R10 sticky level", int'(done_o), (struck > 0) ? 1 : 0);
          end
        end
      end
    end

    // R9: rewriting the same single code re-arms
    byte_mode_i = 1'b0;
    write_mode(2'b10);
    pulse(1, n, first);
    pulse(1, n, first);
    check("R9 spent before rewrite", n, 0);
    write_mode(2'b10);
    pulse(3, n, first);
    check("R9 rearmed by rewrite", n, 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule